// File: doc/BRIEF.md
# Graphic LCD Column Host Interface

This block is the processor-facing half of a 64-column graphic LCD segment driver. A host talks to it over an 8-bit parallel bus made of an enable strobe, a register-select line, a read/write line and three chip-select lines of mixed polarity. The tri-state data bus is split into an input, an output and an output-enable. Behind the bus sits a 512-byte display memory organised as pages of 8 vertical pixels by 64 columns. A 6-bit column counter and a 3-bit page register address this memory. Instructions switch the display on or off, set the first scanned line, and load the page or the column. Reads return either a status byte or the addressed memory byte.

Bus transfers are sampled on the block's own clock. A transfer takes effect on the first clock edge that sees the enable low after seeing it high. It uses the register-select, read/write, chip-select and data values from the last clock edge at which the enable was still high. The display side has a scan read port. Given a page and an output segment index, it returns the byte that feeds that segment. A direction input chooses whether segment indices map to columns in ascending or descending order.

Top module: `lcd_col_host`

## Requirements
- R1: The block is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. Transfers finished while it is not selected change no state: memory, column, page, display flag and start line are all unchanged. `dout_oe` is 0 whenever the block is not selected.
- R2: A write takes effect at the first rising clock edge that samples `bus_en` low after the previous edge sampled it high. It uses `din`, `reg_sel`, `rd_nwr` and the chip selects as sampled at that previous edge. Nothing changes while `bus_en` stays high.
- R3: `dout_oe` is 1 exactly when the block is selected, `rd_nwr`=1 and `bus_en`=1.
- R4: An instruction write (`reg_sel`=0) decodes as follows. Byte 0011111d sets `disp_on` to d. Byte 01cccccc loads the column with c. Byte 10111ppp loads the page with p. Byte 11ssssss sets `start_line` to s. Any other byte has no effect.
- R5: A data write (`reg_sel`=1) stores `din` at the current page and column. A data read returns the byte at the current page and column. Bit value 1 means pixel on.
- R6: Every data write and every data read advances the column by one, wrapping from 63 to 0. The page never changes except by the page instruction.
- R7: A status read (`reg_sel`=0, `rd_nwr`=1) returns bit 7 = busy, bit 5 = display off (inverse of `disp_on`) and bit 4 = reset active. All other bits are 0.
- R8: After each accepted write (instruction or data), busy reads 1 for exactly BUSY_CYC clock cycles. Reads do not set it.
- R9: `scan_data` is the byte at page `scan_page` and at a column that depends on `col_dir`. When `col_dir`=1 the column is `scan_seg`. When `col_dir`=0 the column is 63−`scan_seg`. Segment index 0 is the first output segment.
- R10: While `rst_n` is low, each clock edge clears `disp_on`, `start_line`, the page and the column to 0. During reset, status reads show busy=1 and reset=1. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus enable strobe |
| reg_sel | input | 1 | 1 = display memory data, 0 = instruction/status |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| din | input | 8 | Bus data in |
| dout | output | 8 | Bus data out (0 when not driven) |
| dout_oe | output | 1 | Bus output enable |
| col_dir | input | 1 | Segment-to-column direction |
| scan_page | input | 3 | Page read by the scan port |
| scan_seg | input | 6 | Segment index read by the scan port |
| scan_data | output | 8 | Memory byte for that segment |
| disp_on | output | 1 | Display enabled flag |
| start_line | output | 6 | First scanned line |

## Verification
Some properties are checked by assertions on every cycle. The column advances by exactly one after each data access. The page holds unless a page instruction arrives. Unselected transfers leave all state untouched. The busy window matches a count of cycles since the last accepted write. A stored byte is present in its bank one cycle after the write. Status reads keep their unused bits at zero, and reset clears the display flag and start line. Other behaviours appear only in the bench's scenarios. These are the timing of commits at the enable's falling edge with data changed just after it, the full instruction decode, column wrap within a page, the two segment mappings, and memory surviving a reset taken mid-session.

// File: rtl/lcdhi_pkg.sv
`timescale 1ns/1ps
package lcdhi_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_DISP  = 3'd1,
      OP_COL   = 3'd2,
      OP_PAGE  = 3'd3,
      OP_START = 3'd4
   } op_e;

   typedef struct packed {
      logic       rs;
      logic       rw;
      logic       sel;
      logic [7:0] data;
   } bus_cap_t;

   localparam int STAT_BUSY = 7;
   localparam int STAT_OFF  = 5;
   localparam int STAT_RST  = 4;

   function automatic op_e decode_op(input logic [7:0] b);
      op_e r;
      r = OP_NONE;
      if (b[7:6] == 2'b01)           r = OP_COL;
      else if (b[7:6] == 2'b11)      r = OP_START;
      else if (b[7:1] == 7'b0011111) r = OP_DISP;
      else if (b[7:3] == 5'b10111)   r = OP_PAGE;
      return r;
   endfunction

endpackage

// File: rtl/lcdhi_strobe.sv
`timescale 1ns/1ps
module lcdhi_strobe
   import lcdhi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_en,
   input  logic       rs,
   input  logic       rw,
   input  logic       sel,
   input  logic [7:0] din,
   output logic       commit,
   output bus_cap_t   cap
);

   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= bus_en;
   end

   // snapshot taken at every edge that still sees the strobe high
   always_ff @(posedge clk) begin
      if (bus_en) begin
         cap.rs   <= rs;
         cap.rw   <= rw;
         cap.sel  <= sel;
         cap.data <= din;
      end
   end

   assign commit = en_q & ~bus_en;

endmodule

// File: rtl/lcdhi_ctrl.sv
`timescale 1ns/1ps
module lcdhi_ctrl
   import lcdhi_pkg::*;
#(
   parameter int COLS     = 64,
   parameter int PAGES    = 8,
   parameter int LINES    = 64,
   parameter int BUSY_CYC = 4,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES),
   localparam int LW = $clog2(LINES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  bus_cap_t      cap,
   output logic [PW-1:0] page,
   output logic [CW-1:0] col,
   output logic          disp_on,
   output logic [LW-1:0] start_line,
   output logic          busy,
   output logic          ram_we,
   output logic [7:0]    ram_wdata
);

   op_e  op;
   logic instr_wr, data_acc, acc_wr;

   assign op       = decode_op(cap.data);
   assign acc_wr   = commit & cap.sel & ~cap.rw;
   assign instr_wr = acc_wr & ~cap.rs;
   assign data_acc = commit & cap.sel & cap.rs;
   assign ram_we    = acc_wr & cap.rs;
   assign ram_wdata = cap.data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page       <= '0;
         col        <= '0;
         disp_on    <= 1'b0;
         start_line <= '0;
      end else begin
         if (instr_wr) begin
            unique case (op)
               OP_DISP:  disp_on    <= cap.data[0];
               OP_COL:   col        <= cap.data[CW-1:0];
               OP_PAGE:  page       <= cap.data[PW-1:0];
               OP_START: start_line <= cap.data[LW-1:0];
               default:  ;
            endcase
         end
         if (data_acc) col <= col + 1'b1;
      end
   end

   generate
      if (BUSY_CYC > 0) begin : g_busy
         localparam int BW = $clog2(BUSY_CYC + 1);
         logic [BW-1:0] busy_cnt;
         logic [BW:0]   since_wr;

         always_ff @(posedge clk) begin
            if (!rst_n)               busy_cnt <= '0;
            else if (acc_wr)          busy_cnt <= BW'(BUSY_CYC);
            else if (busy_cnt != '0)  busy_cnt <= busy_cnt - 1'b1;
         end
         assign busy = (busy_cnt != '0);

         // checker: cycles elapsed since the last accepted write
         always_ff @(posedge clk) begin
            if (!rst_n)                           since_wr <= (BW+1)'(BUSY_CYC);
            else if (acc_wr)                      since_wr <= '0;
            else if (since_wr < (BW+1)'(BUSY_CYC)) since_wr <= since_wr + 1'b1;
         end

         assert_busy_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
            busy == (since_wr < (BW+1)'(BUSY_CYC)))
            else $error("busy window wrong");
      end else begin : g_nobusy
         assign busy = 1'b0;
      end
   endgenerate

   assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_acc |=> col == CW'($past(col) + 1'b1))
      else $error("column did not advance");

   assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_wr && op == OP_PAGE) |=> $stable(page))
      else $error("page moved without instruction");

   assert_unsel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !cap.sel) |=> ($stable(col) && $stable(page) &&
                                $stable(disp_on) && $stable(start_line)))
      else $error("unselected transfer changed state");

endmodule

// File: rtl/lcdhi_ram.sv
`timescale 1ns/1ps
module lcdhi_ram #(
   parameter int COLS  = 64,
   parameter int PAGES = 8,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [PW-1:0] wpage,
   input  logic [CW-1:0] wcol,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic [PW-1:0] spage,
   input  logic [CW-1:0] sseg,
   input  logic          col_dir,
   output logic [7:0]    sdata
);

   logic [7:0]    host_b [PAGES];
   logic [7:0]    scan_b [PAGES];
   logic [CW-1:0] scol;

   assign scol = col_dir ? sseg : (CW'(COLS - 1) - sseg);

   generate
      for (genvar p = 0; p < PAGES; p++) begin : g_page
         logic [7:0] mem [COLS];

         always_ff @(posedge clk) begin
            if (we && wpage == PW'(p)) mem[wcol] <= wdata;
         end

         assign host_b[p] = mem[wcol];
         assign scan_b[p] = mem[scol];

         assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wpage == PW'(p)) |=> mem[$past(wcol)] == $past(wdata))
            else $error("byte not stored");
      end
   endgenerate

   assign rdata = host_b[wpage];
   assign sdata = scan_b[spage];

endmodule

// File: rtl/lcd_col_host.sv
`timescale 1ns/1ps
module lcd_col_host
   import lcdhi_pkg::*;
#(
   parameter int COLS     = 64,
   parameter int PAGES    = 8,
   parameter int LINES    = 64,
   parameter int BUSY_CYC = 4,
   localparam int CW = $clog2(COLS),
   localparam int PW = $clog2(PAGES),
   localparam int LW = $clog2(LINES)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_en,
   input  logic          reg_sel,
   input  logic          rd_nwr,
   input  logic          cs_a_n,
   input  logic          cs_b_n,
   input  logic          cs_c,
   input  logic [7:0]    din,
   output logic [7:0]    dout,
   output logic          dout_oe,
   input  logic          col_dir,
   input  logic [PW-1:0] scan_page,
   input  logic [CW-1:0] scan_seg,
   output logic [7:0]    scan_data,
   output logic          disp_on,
   output logic [LW-1:0] start_line
);

   generate
      if (COLS != (1 << CW) || CW > 6 || CW < 1) begin : g_bad_cols
         $error("COLS must be a power of two from 2 to 64");
      end
      if (PAGES != (1 << PW) || PW > 3 || PW < 1) begin : g_bad_pages
         $error("PAGES must be a power of two from 2 to 8");
      end
      if (LINES != (1 << LW) || LW > 6 || LW < 1) begin : g_bad_lines
         $error("LINES must be a power of two from 2 to 64");
      end
      if (BUSY_CYC < 0) begin : g_bad_busy
         $error("BUSY_CYC must not be negative");
      end
   endgenerate

   logic          sel, commit, busy_raw, ram_we;
   bus_cap_t      cap;
   logic [PW-1:0] page;
   logic [CW-1:0] col;
   logic [7:0]    ram_wdata, ram_rdata, status;

   assign sel = ~cs_a_n & ~cs_b_n & cs_c;

   lcdhi_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .rs(reg_sel), .rw(rd_nwr),
      .sel(sel), .din(din), .commit(commit), .cap(cap)
   );

   lcdhi_ctrl #(.COLS(COLS), .PAGES(PAGES), .LINES(LINES), .BUSY_CYC(BUSY_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cap(cap),
      .page(page), .col(col), .disp_on(disp_on), .start_line(start_line),
      .busy(busy_raw), .ram_we(ram_we), .ram_wdata(ram_wdata)
   );

   lcdhi_ram #(.COLS(COLS), .PAGES(PAGES)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .wpage(page), .wcol(col),
      .wdata(ram_wdata), .rdata(ram_rdata), .spage(scan_page), .sseg(scan_seg),
      .col_dir(col_dir), .sdata(scan_data)
   );

   always_comb begin
      status = '0;
      status[STAT_BUSY] = busy_raw | ~rst_n;
      status[STAT_OFF]  = ~disp_on;
      status[STAT_RST]  = ~rst_n;
   end

   assign dout_oe = sel & rd_nwr & bus_en;
   assign dout    = !dout_oe ? 8'h00 : (reg_sel ? ram_rdata : status);

   assert_no_drive_unsel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs_a_n == 1'b0 && cs_b_n == 1'b0 && cs_c == 1'b1) |-> !dout_oe)
      else $error("bus driven while not selected");

   assert_status_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_oe && !reg_sel) |-> (dout[6] == 1'b0 && dout[3:0] == 4'h0))
      else $error("status reserved bits set");

   assert_reset_clear_R10: assert property (@(posedge clk)
      !rst_n |=> (!disp_on && start_line == '0))
      else $error("reset did not clear display state");

endmodule

// File: tb/sim_lcd_col_host.sv
`timescale 1ns/1ps
module sim_lcd_col_host;

   localparam int BUSY_CYC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0, reg_sel = 1'b0, rd_nwr = 1'b0;
   logic       cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
   logic [7:0] din = 8'h00;
   logic       col_dir = 1'b1;
   logic [2:0] scan_page = 3'd0;
   logic [5:0] scan_seg = 6'd0;
   logic [7:0] dout, scan_data;
   logic       dout_oe, disp_on;
   logic [5:0] start_line;

   always #2.5 clk = ~clk;

   lcd_col_host u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .reg_sel(reg_sel), .rd_nwr(rd_nwr),
      .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .cs_c(cs_c), .din(din), .dout(dout),
      .dout_oe(dout_oe), .col_dir(col_dir), .scan_page(scan_page), .scan_seg(scan_seg),
      .scan_data(scan_data), .disp_on(disp_on), .start_line(start_line)
   );

   int  nvec = 0, nfail = 0, ncyc = 0;
   bit  started = 0, done = 0, scan_auto = 1;

   // behavioural reference model
   logic [7:0] m_ram [8][64];
   bit         m_val [8][64];
   int         m_page = 0, m_col = 0, m_start = 0, m_busy = 0;
   bit         m_on = 0, m_eprev = 0;
   bit         c_rs, c_rw, c_sel;
   logic [7:0] c_d;

   function automatic bit selected();
      return (cs_a_n == 1'b0 && cs_b_n == 1'b0 && cs_c == 1'b1);
   endfunction

   always @(posedge clk) begin
      ncyc++;
      if (!rst_n) begin
         m_on = 0; m_start = 0; m_page = 0; m_col = 0; m_eprev = 0;
      end else begin
         if (m_busy > 0) m_busy--;
         if (m_eprev && !bus_en && c_sel) begin
            if (!c_rw) m_busy = BUSY_CYC;
            if (c_rs) begin
               if (!c_rw) begin m_ram[m_page][m_col] = c_d; m_val[m_page][m_col] = 1; end
               m_col = (m_col + 1) % 64;
            end else if (!c_rw) begin
               if (c_d[7:1] == 7'b0011111)  m_on = c_d[0];
               else if (c_d[7:6] == 2'b01)  m_col = c_d[5:0];
               else if (c_d[7:3] == 5'b10111) m_page = c_d[2:0];
               else if (c_d[7:6] == 2'b11)  m_start = c_d[5:0];
            end
         end
         if (bus_en) begin c_rs = reg_sel; c_rw = rd_nwr; c_sel = selected(); c_d = din; end
         m_eprev = bus_en;
      end
   end

   task automatic bad(string req, string what, int act, int exp);
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
   endtask

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nvec++;
      if (!ok) bad(req, what, act, exp);
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (started && !done) begin
         bit exp_oe;
         int sc;
         logic [7:0] st;
         nvec++;
         exp_oe = selected() && rd_nwr && bus_en;
         if (dout_oe !== exp_oe) bad("R3", "dout_oe", dout_oe, exp_oe);
         if (exp_oe && !reg_sel) begin
            st = {(!rst_n || m_busy > 0), 1'b0, !m_on, !rst_n, 4'h0};
            if (dout !== st) bad("R7", "status", dout, st);
         end else if (exp_oe && reg_sel && m_val[m_page][m_col]) begin
            if (dout !== m_ram[m_page][m_col]) bad("R5", "data read", dout, m_ram[m_page][m_col]);
         end
         if (disp_on !== m_on) bad("R4", "disp_on", disp_on, m_on);
         if (start_line !== 6'(m_start)) bad("R4", "start_line", start_line, m_start);
         sc = col_dir ? int'(scan_seg) : 63 - int'(scan_seg);
         if (m_val[scan_page][sc] && scan_data !== m_ram[scan_page][sc])
            bad("R9", "scan_data", scan_data, m_ram[scan_page][sc]);
      end
   end

   always @(posedge clk) begin
      if (scan_auto) begin
         #1;
         scan_page = 3'(ncyc % 8);
         scan_seg  = 6'((ncyc * 7) % 64);
      end
   end

   task automatic step(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cs_set(bit a, bit b, bit c);
      cs_a_n = a; cs_b_n = b; cs_c = c;
   endtask

   // write: data changed at the same moment the strobe drops (R2)
   task automatic wr(bit rs, logic [7:0] d);
      step();
      reg_sel = rs; rd_nwr = 1'b0; din = d; bus_en = 1'b1;
      step(2);
      bus_en = 1'b0; din = ~d;
      step(2);
   endtask

   task automatic rd_any(bit rs);
      step();
      reg_sel = rs; rd_nwr = 1'b1; bus_en = 1'b1;
      step(2);
      bus_en = 1'b0;
      step(2);
      rd_nwr = 1'b0;
   endtask

   task automatic rd(bit rs, logic [7:0] exp, string req);
      step();
      reg_sel = rs; rd_nwr = 1'b1; bus_en = 1'b1;
      @(negedge clk);
      chk(dout_oe === 1'b1 && dout === exp, req, "read", dout, exp);
      step();
      bus_en = 1'b0;
      step(2);
      rd_nwr = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (ncyc > 100000) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 100000);
            finish_run();
         end
      end
   end

   initial begin
      @(posedge clk);
      started = 1;
      #1;
      // R10: status during reset shows busy, off and reset
      cs_set(0, 0, 1);
      rd(0, 8'hB0, "R10");
      step(2);
      rst_n = 1'b1;
      step(2);
      chk(disp_on === 1'b0 && start_line === 6'd0, "R10", "after reset", disp_on, 0);
      rd(0, 8'h20, "R7");

      // R4 display on; R8 busy right after the write
      wr(0, 8'h3F);
      chk(disp_on === 1'b1, "R4", "display on", disp_on, 1);
      rd(0, 8'h80, "R8");
      step(8);
      rd(0, 8'h00, "R7");

      wr(0, 8'hC5);
      chk(start_line === 6'd5, "R4", "start line", start_line, 5);
      wr(0, 8'h00); // R4 undefined byte is ignored
      chk(disp_on === 1'b1 && start_line === 6'd5, "R4", "ignored byte", start_line, 5);

      // R5/R6 writes across column wrap on page 3, then read back
      wr(0, 8'hBB);
      wr(0, 8'h40 | 8'd62);
      wr(1, 8'hA1); wr(1, 8'hB2); wr(1, 8'hC3);
      wr(0, 8'h40 | 8'd62);
      rd(1, 8'hA1, "R5");
      rd(1, 8'hB2, "R6");
      rd(1, 8'hC3, "R6");

      // R1 unselected writes and reads
      wr(0, 8'h40 | 8'd10);
      wr(1, 8'h5A);
      wr(0, 8'h40 | 8'd10);
      cs_set(1, 0, 1); wr(1, 8'hFF); wr(0, 8'h3E);
      cs_set(0, 1, 1); wr(1, 8'hFF); wr(0, 8'hC9);
      cs_set(0, 0, 0); wr(1, 8'hFF); wr(0, 8'hB8);
      step();
      reg_sel = 1'b0; rd_nwr = 1'b1; bus_en = 1'b1;
      @(negedge clk);
      chk(dout_oe === 1'b0, "R1", "unselected drive", dout_oe, 0);
      step(); bus_en = 1'b0; rd_nwr = 1'b0; step(2);
      cs_set(0, 0, 1);
      chk(disp_on === 1'b1 && start_line === 6'd5, "R1", "unselected instr", disp_on, 1);
      rd(1, 8'h5A, "R1");

      // R2 nothing happens while the strobe stays high
      step();
      reg_sel = 1'b0; rd_nwr = 1'b0; din = 8'h3E; bus_en = 1'b1;
      step(3);
      @(negedge clk);
      chk(disp_on === 1'b1, "R2", "held strobe", disp_on, 1);
      step();
      bus_en = 1'b0; din = 8'h3F;
      step(2);
      chk(disp_on === 1'b0, "R2", "commit after fall", disp_on, 0);

      // R9 both segment mappings
      wr(0, 8'hB8); wr(0, 8'h40);
      wr(1, 8'h11); wr(1, 8'h22);
      scan_auto = 0;
      step();
      scan_page = 3'd0; scan_seg = 6'd0; col_dir = 1'b1;
      @(negedge clk);
      chk(scan_data === 8'h11, "R9", "ascending seg0", scan_data, 8'h11);
      step();
      col_dir = 1'b0; scan_seg = 6'd62;
      @(negedge clk);
      chk(scan_data === 8'h22, "R9", "descending seg62", scan_data, 8'h22);
      step();
      col_dir = 1'b1; scan_auto = 1;

      // page 7 write/read
      wr(0, 8'hBF); wr(0, 8'h40 | 8'd33); wr(1, 8'h96);
      wr(0, 8'h40 | 8'd33);
      rd(1, 8'h96, "R5");

      // R10 reset mid-session: flags cleared, memory kept
      wr(0, 8'h3F);
      step();
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step();
      chk(disp_on === 1'b0 && start_line === 6'd0, "R10", "mid reset", disp_on, 0);
      rd(1, 8'h11, "R10");

      // mixed traffic compared every cycle
      for (int i = 0; i < 300; i++) begin
         int k;
         k = $urandom % 5;
         case (k)
            0, 1: wr(1, 8'($urandom));
            2:    rd_any(1);
            3:    wr(0, 8'h40 | 8'($urandom % 64));
            default: wr(0, 8'hB8 | 8'($urandom % 8));
         endcase
         if (i % 50 == 0) col_dir = ~col_dir;
      end
      step(4);
      finish_run();
   end

endmodule